// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits on the controller side of a single SDRAM device. It owns the RAS, CAS, WE and CKE command pins while it issues auto-refresh commands or moves the device into or out of self-refresh or power-down. A refresh can be requested with a one-cycle pulse. It also falls due by itself from an internal interval timer. Self-refresh and power-down are level requests: the device stays in the state while the request is held.

The access engine reports every ACTIVATE and PRECHARGE it issues as per-bank pulses. From these the sequencer tracks which banks are open and how long ago the last precharge occurred. The sequencer starts a refresh or a low-power entry only when every bank is closed and the precharge recovery time has passed. Its `ready_o` output tells the access engine when it may drive commands. Ready is withheld during each row-cycle window, during low-power residency and in the cycle in which the sequencer claims the pins. A sticky flag records that a pending refresh forced the device out of power-down.

Top module: `sdram_pwr_seq`

## Requirements
- R1: After reset the pins hold NOP (RAS, CAS and WE high), CKE is high, `ready_o` is high and `pd_wake_o` is low.
- R2: A refresh is pending after a one-cycle pulse on `ref_req_i`. When it is pending, all banks are closed, tRP has elapsed and no spacing window is open, the cycle after the decision carries the auto-refresh code (RAS low, CAS low, WE high) with CKE high for exactly one cycle. The pending request is then cleared.
- R3: After an auto-refresh in cycle k, `ready_o` stays low up to and including cycle k+TRC-1 and is high again in cycle k+TRC. No later auto-refresh appears before cycle k+TRC.
- R4: If no refresh is requested, an auto-refresh appears exactly REF_INT cycles after the previous one. The interval restarts at self-refresh exit, so the first automatic refresh appears REF_INT cycles after the cycle in which CKE rises.
- R5: Self-refresh entry drives the auto-refresh code together with CKE low for one cycle. After that, while `self_ref_req_i` stays high, CKE stays low and the pins hold NOP.
- R6: When `self_ref_req_i` falls, CKE returns high with NOP in the next cycle. `ready_o` then stays low for TRC cycles counted from that cycle. Refresh requests made during self-refresh are absorbed and cause no extra refresh.
- R7: No auto-refresh, self-refresh entry or power-down entry starts while any bank is open. None starts earlier than TRP+1 cycles after the cycle of the last precharge. Until then the pins hold NOP and `ready_o` may remain high.
- R8: Power-down entry takes CKE low, with NOP, one cycle after the decision. When `pwr_down_req_i` falls, CKE rises in the next cycle with `ready_o` low, and `ready_o` returns high one cycle later.
- R9: A refresh that becomes due during power-down forces the device out: CKE rises in the next cycle and the auto-refresh follows two cycles after that. This applies to both a request and timer expiry. Such a forced exit sets `pd_wake_o`, which then stays high until reset.
- R10: `ready_o` is low whenever CKE is low, in any cycle in which the sequencer decides to start an operation, and while a spacing window is open. When several requests compete, refresh wins over self-refresh, and self-refresh wins over power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req_i | input | 1 | One-cycle pulse requesting an auto-refresh |
| self_ref_req_i | input | 1 | Level request to hold the device in self-refresh |
| pwr_down_req_i | input | 1 | Level request to hold the device in power-down |
| bank_act_i | input | NB | Per-bank pulse: access engine activated this bank |
| bank_pre_i | input | NB | Per-bank pulse: access engine precharged this bank |
| ras_n_o | output | 1 | Row strobe command pin, active low |
| cas_n_o | output | 1 | Column strobe command pin, active low |
| we_n_o | output | 1 | Write enable command pin, active low |
| cke_o | output | 1 | Clock enable pin |
| ready_o | output | 1 | Access engine may issue commands this cycle |
| pd_wake_o | output | 1 | Sticky: power-down was left because a refresh was due |

## Verification
Several rules are checked by assertions on every cycle:
- Two auto-refreshes are never closer than TRC.
- CKE only falls with all banks closed and never falls inside the precharge window.
- The pins hold NOP during low-power residency.
- Ready is never high while CKE is low or in the cycle CKE rises.
- The wake flag never clears.

Only the bench scenarios can show the rest: the exact cycles of each entry and exit, the timer period and its restart after self-refresh, the absorption of requests made during self-refresh, and the priority of refresh over a held power-down request.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_SELF = 2'd1,
      SEQ_DOWN = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sdr_cmd_t;

   localparam sdr_cmd_t CMD_NOP  = 3'b111;
   localparam sdr_cmd_t CMD_AREF = 3'b001;

endpackage

// File: rtl/seq_bank_track.sv
module seq_bank_track #(
   parameter int unsigned NB  = 4,
   parameter int unsigned TRP = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] bank_act_i,
   input  logic [NB-1:0] bank_pre_i,
   output logic          all_closed_o,
   output logic          trp_done_o
);

   logic [NB-1:0] open_q;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              open_q[b] <= 1'b0;
         else if (bank_pre_i[b])  open_q[b] <= 1'b0;
         else if (bank_act_i[b])  open_q[b] <= 1'b1;
      end
   end

   assign all_closed_o = (open_q == '0);

   if (TRP > 1) begin : g_trp_cnt
      localparam int unsigned TW = $clog2(TRP);
      logic [TW-1:0] trp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             trp_q <= '0;
         else if (|bank_pre_i)   trp_q <= TW'(TRP - 1);
         else if (trp_q != '0)   trp_q <= trp_q - 1'b1;
      end

      assign trp_done_o = (trp_q == '0);

      AST_TRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (|bank_pre_i) |=> !trp_done_o); // R7
   end else begin : g_trp_none
      // The open mask already lags a precharge by one cycle.
      assign trp_done_o = 1'b1;
   end

endmodule

// File: rtl/seq_ref_timer.sv
module seq_ref_timer #(
   parameter int unsigned REF_INT = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic due_o
);

   localparam int unsigned CW = $clog2(REF_INT);
   localparam logic [CW-1:0] LAST = CW'(REF_INT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (restart_i)    cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign due_o = (cnt_q == LAST);

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
   import sdram_pwr_pkg::*;
#(
   parameter int unsigned NB      = 4,
   parameter int unsigned TRC     = 7,
   parameter int unsigned TRP     = 3,
   parameter int unsigned REF_INT = 1560
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_req_i,
   input  logic          self_ref_req_i,
   input  logic          pwr_down_req_i,
   input  logic [NB-1:0] bank_act_i,
   input  logic [NB-1:0] bank_pre_i,
   output logic          ras_n_o,
   output logic          cas_n_o,
   output logic          we_n_o,
   output logic          cke_o,
   output logic          ready_o,
   output logic          pd_wake_o
);

   localparam int unsigned GW = $clog2(TRC + 1);

   if (TRC < 2) begin : g_bad_trc
      $error("sdram_pwr_seq: TRC must be at least 2");
   end
   if (TRP < 1) begin : g_bad_trp
      $error("sdram_pwr_seq: TRP must be at least 1");
   end
   if (REF_INT <= TRC + 2) begin : g_bad_int
      $error("sdram_pwr_seq: REF_INT must exceed TRC + 2");
   end
   if (NB < 1) begin : g_bad_nb
      $error("sdram_pwr_seq: NB must be at least 1");
   end

   seq_state_e    state_q, state_d;
   sdr_cmd_t      cmd_q, cmd_d;
   logic          cke_q, cke_d;
   logic [GW-1:0] gap_q, gap_d;
   logic          pend_q, pend_d;
   logic          wake_q, wake_d;

   logic all_closed, trp_done, ref_due;
   logic need_ref, can_start, go_ref, go_self, go_down;
   logic leave_self, leave_down;

   seq_bank_track #(.NB(NB), .TRP(TRP)) u_banks (
      .clk          (clk),
      .rst_n        (rst_n),
      .bank_act_i   (bank_act_i),
      .bank_pre_i   (bank_pre_i),
      .all_closed_o (all_closed),
      .trp_done_o   (trp_done)
   );

   seq_ref_timer #(.REF_INT(REF_INT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (go_ref | (state_q == SEQ_SELF)),
      .due_o     (ref_due)
   );

   always_comb begin
      need_ref   = ref_req_i | pend_q | ref_due;
      can_start  = (state_q == SEQ_RUN) && (gap_q == '0) && all_closed && trp_done;
      go_ref     = can_start && need_ref;
      go_self    = can_start && !need_ref && self_ref_req_i;
      go_down    = can_start && !need_ref && !self_ref_req_i && pwr_down_req_i;
      leave_self = (state_q == SEQ_SELF) && !self_ref_req_i;
      leave_down = (state_q == SEQ_DOWN) && (!pwr_down_req_i || need_ref);
   end

   always_comb begin
      state_d = state_q;
      cmd_d   = CMD_NOP;
      cke_d   = 1'b1;
      gap_d   = (gap_q != '0) ? gap_q - 1'b1 : '0;
      unique case (state_q)
         SEQ_RUN: begin
            if (go_ref) begin
               cmd_d = CMD_AREF;
               gap_d = GW'(TRC);
            end else if (go_self) begin
               cmd_d   = CMD_AREF;
               cke_d   = 1'b0;
               state_d = SEQ_SELF;
            end else if (go_down) begin
               cke_d   = 1'b0;
               state_d = SEQ_DOWN;
            end
         end
         SEQ_SELF: begin
            cke_d = 1'b0;
            if (leave_self) begin
               cke_d   = 1'b1;
               gap_d   = GW'(TRC);
               state_d = SEQ_RUN;
            end
         end
         SEQ_DOWN: begin
            cke_d = 1'b0;
            if (leave_down) begin
               cke_d   = 1'b1;
               gap_d   = GW'(1);
               state_d = SEQ_RUN;
            end
         end
         default: state_d = SEQ_RUN;
      endcase
   end

   always_comb begin
      if (leave_self || go_ref) pend_d = 1'b0;
      else                      pend_d = pend_q | ref_req_i;
      wake_d = wake_q | ((state_q == SEQ_DOWN) && need_ref);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_RUN;
         cmd_q   <= CMD_NOP;
         cke_q   <= 1'b1;
         gap_q   <= '0;
         pend_q  <= 1'b0;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cmd_q   <= cmd_d;
         cke_q   <= cke_d;
         gap_q   <= gap_d;
         pend_q  <= pend_d;
         wake_q  <= wake_d;
      end
   end

   assign ras_n_o   = cmd_q.ras_n;
   assign cas_n_o   = cmd_q.cas_n;
   assign we_n_o    = cmd_q.we_n;
   assign cke_o     = cke_q;
   assign pd_wake_o = wake_q;
   assign ready_o   = (state_q == SEQ_RUN) && (gap_q == '0) && !go_ref && !go_self && !go_down;

   // Cycles since the last refresh code on the pins, saturating at TRC.
   logic [GW-1:0] since_ref_q;
   logic          aref_on_pins;
   assign aref_on_pins = (cmd_q == CMD_AREF) && cke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    since_ref_q <= GW'(TRC);
      else if (aref_on_pins)         since_ref_q <= GW'(1);
      else if (since_ref_q != GW'(TRC)) since_ref_q <= since_ref_q + 1'b1;
   end

   AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      aref_on_pins |-> (since_ref_q == GW'(TRC))); // R3

   AST_CKE_FALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (all_closed && $past(trp_done))); // R7

   AST_LOWPWR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_o && $past(!cke_o)) |-> (ras_n_o && cas_n_o && we_n_o)); // R5

   AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> cke_o); // R10

   AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> !ready_o); // R8

   AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(pd_wake_o)); // R9

endmodule

// File: tb/sdram_pwr_seq_tb.sv
module sdram_pwr_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB      = 4;
   localparam int TRC     = 6;
   localparam int TRP     = 3;
   localparam int REF_INT = 100;

   localparam logic [5:0] M_PIN = 6'b111100;
   localparam logic [5:0] M_RDY = 6'b000010;
   localparam logic [5:0] M_CKE = 6'b000100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_req = 1'b0, self_req = 1'b0, pd_req = 1'b0;
   logic [NB-1:0] bank_act = '0, bank_pre = '0;
   logic ras_n, cas_n, we_n, cke, ready, wake;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;

   typedef struct {
      int         at;
      logic [5:0] val;
      logic [5:0] mask;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdram_pwr_seq #(.NB(NB), .TRC(TRC), .TRP(TRP), .REF_INT(REF_INT)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .ref_req_i      (ref_req),
      .self_ref_req_i (self_req),
      .pwr_down_req_i (pd_req),
      .bank_act_i     (bank_act),
      .bank_pre_i     (bank_pre),
      .ras_n_o        (ras_n),
      .cas_n_o        (cas_n),
      .we_n_o         (we_n),
      .cke_o          (cke),
      .ready_o        (ready),
      .pd_wake_o      (wake)
   );

   // Observed vector: {ras_n, cas_n, we_n, cke, ready, wake}
   always @(negedge clk) begin
      logic [5:0] act;
      act = {ras_n, cas_n, we_n, cke, ready, wake};
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].at == cyc) begin
            n_checks++;
            if ((act & sb_q[i].mask) !== (sb_q[i].val & sb_q[i].mask)) begin
               n_fail++;
               $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                        sb_q[i].tag, cyc, act, sb_q[i].val, sb_q[i].mask);
            end
            sb_q.delete(i);
         end else if (sb_q[i].at < cyc) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s cycle %0d: actual missed expected %b", sb_q[i].tag,
                     sb_q[i].at, sb_q[i].val);
            sb_q.delete(i);
         end
      end
   end

   task automatic expect_at(int at, logic [5:0] v, logic [5:0] m, string t);
      sb_q.push_back('{at, v, m, t});
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_until(int t);
      while (cyc < t) tick();
   endtask

   task automatic pulse_ref();
      ref_req = 1'b1; tick(); ref_req = 1'b0;
   endtask

   task automatic run_all();
      int r, c, k, k2, a, j, e, f, k3, g, s, x, k5, j2;
      repeat (5) tick();
      rst_n = 1'b1;
      r = cyc;
      expect_at(r, 6'b111110, 6'b111111, "R1");
      tick(); tick();

      // Requested refresh, spacing, then automatic refresh
      c = cyc;
      expect_at(c,       6'b000000, M_RDY,     "R10");
      expect_at(c + 1,   6'b001100, 6'b111110, "R2");
      expect_at(c + 2,   6'b111100, M_PIN,     "R2");
      expect_at(c + 6,   6'b000000, M_RDY,     "R3");
      expect_at(c + 7,   6'b000010, M_RDY,     "R3");
      expect_at(c + 100, 6'b111100, M_PIN,     "R4");
      expect_at(c + 101, 6'b001100, M_PIN,     "R4");
      pulse_ref();

      // Burst: a second request right after a refresh waits out TRC
      k = c + 101;
      wait_until(k + 1);
      expect_at(k + 6, 6'b111100, 6'b111110, "R3");
      expect_at(k + 7, 6'b001100, M_PIN,     "R3");
      pulse_ref();

      // Power-down blocked by an open bank and by tRP
      k2 = k + 7;
      a = k2 + 8;
      j = a + 4;
      e = j + 10;
      wait_until(a);
      bank_act = 4'b0001; tick(); bank_act = '0;
      pd_req = 1'b1;
      expect_at(j + 2, 6'b000110, 6'b000110, "R7");
      expect_at(j + 3, 6'b000100, 6'b000110, "R7");
      expect_at(j + 4, 6'b111000, 6'b111110, "R8");
      expect_at(e,     6'b000000, M_CKE,     "R8");
      expect_at(e + 1, 6'b111100, 6'b111110, "R8");
      expect_at(e + 2, 6'b000010, M_RDY,     "R8");
      wait_until(j);
      bank_pre = 4'b0001; tick(); bank_pre = '0;
      wait_until(e);
      pd_req = 1'b0;

      // Refresh request inside power-down forces exit
      wait_until(e + 3);
      pd_req = 1'b1;
      f = e + 8;
      k3 = f + 3;
      expect_at(e + 4,   6'b111000, M_PIN,     "R8");
      expect_at(f,       6'b000000, 6'b000101, "R9");
      expect_at(f + 1,   6'b000101, 6'b000111, "R9");
      expect_at(f + 3,   6'b001101, 6'b111101, "R9");
      expect_at(f + 9,   6'b000100, 6'b000110, "R3");
      expect_at(f + 10,  6'b000000, M_CKE,     "R9");
      expect_at(k3 + 99, 6'b000000, M_CKE,     "R9");
      expect_at(k3 + 100, 6'b000100, 6'b000110, "R9");
      expect_at(k3 + 102, 6'b001100, M_PIN,    "R9");
      expect_at(k3 + 109, 6'b000000, M_CKE,    "R8");
      wait_until(f);
      pulse_ref();
      wait_until(k3 + 112);
      pd_req = 1'b0;
      g = k3 + 113;
      expect_at(g,     6'b000100, M_CKE, "R8");
      expect_at(g + 1, 6'b000010, M_RDY, "R8");

      // Self-refresh with an absorbed request
      s = g + 3;
      x = s + 20;
      expect_at(s,       6'b000000, M_RDY,     "R10");
      expect_at(s + 1,   6'b001000, 6'b111110, "R5");
      expect_at(s + 2,   6'b111000, M_PIN,     "R5");
      expect_at(x,       6'b111000, M_PIN,     "R5");
      expect_at(x + 1,   6'b111100, 6'b111110, "R6");
      expect_at(x + 6,   6'b000000, M_RDY,     "R6");
      expect_at(x + 7,   6'b000010, M_RDY,     "R6");
      expect_at(x + 8,   6'b111100, M_PIN,     "R6");
      expect_at(x + 100, 6'b111100, M_PIN,     "R4");
      expect_at(x + 101, 6'b001100, M_PIN,     "R4");
      wait_until(s);
      self_req = 1'b1;
      wait_until(s + 5);
      pulse_ref();
      wait_until(x);
      self_req = 1'b0;

      // Refresh held back by an open bank and tRP
      k5 = x + 101;
      j2 = k5 + 12;
      expect_at(k5 + 10, 6'b111110, 6'b111110, "R7");
      expect_at(j2 + 3,  6'b111100, 6'b111110, "R7");
      expect_at(j2 + 4,  6'b001100, M_PIN,     "R7");
      wait_until(k5 + 7);
      bank_act = 4'b0100; tick(); bank_act = '0;
      wait_until(k5 + 9);
      pulse_ref();
      wait_until(j2);
      bank_pre = 4'b0100; tick(); bank_pre = '0;
      wait_until(j2 + 10);
   endtask

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      while (sb_q.size() > 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL %s: actual unchecked expected %b at cycle %0d",
                  sb_q[0].tag, sb_q[0].val, sb_q[0].at);
         void'(sb_q.pop_front());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule